// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous x1 DRAM with a multiplexed row/column address bus alive by issuing refresh cycles at a steady rate. An interval timer counts system clocks. Each time the interval elapses it adds one to a small pending count, and it raises a request while that count is non-zero. When the memory access controller grants the request, the block drives the RAS/CAS strobes through one complete refresh sequence and pulses a completion flag. It then removes one refresh from the pending count. Refreshes that the controller defers build up in the pending count, which saturates at its largest value.

Three sequence styles are selected per refresh with a 2-bit mode input, which is sampled at the grant:
- **Row-strobe-only:** CAS stays high, and the block supplies the row from its own wrapping row counter.
- **Column-before-row (CBR):** CAS falls ahead of RAS, and the memory picks the row itself.
- **Hidden:** CAS is held low across a RAS precharge and a fresh RAS low pulse, the way a refresh is tucked in after a read.

Write enable is tied high, so a CBR sequence can never enter the memory's test mode. All strobe widths are parameters counted in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset is released, `req_o` rises on the clock edge `INTERVAL` cycles after internal reset release (two synchronizer cycles after `rst_n` rises). One further refresh becomes pending every `INTERVAL` cycles after that.
- R2: Each interval expiry adds one to a pending count, and each `done_o` pulse removes one. `req_o` is high exactly while the count is non-zero. The count saturates at 2^`PEND_W`-1, and expiries beyond that are dropped.
- R3: A sequence starts only when `grant_i` is high while the block is idle and `req_o` is high. A grant at any other time has no effect on the strobes, `done_o` or the pending count.
- R4: CBR mode (`mode_i` = 2'b01, and also 2'b11) works as follows, counting from the cycle after the grant:
  - CAS_n is low and RAS_n is high for `T_CSR` cycles.
  - Then RAS_n and CAS_n are both low for `T_RAS` cycles.
  - Then both are high for `T_RP` cycles.
- R5: Row-strobe-only mode (`mode_i` = 2'b00) works as follows:
  - CAS_n stays high throughout.
  - RAS_n is high for `T_CSR` cycles, low for `T_RAS` cycles, then high for `T_RP` cycles.
  - `row_o` is stable throughout the sequence.
- R6: Hidden mode (`mode_i` = 2'b10) works as follows:
  - CAS_n is low with RAS_n high for `T_RP` cycles.
  - Then both are low for `T_RAS` cycles.
  - Then both are high for `T_RP` cycles.
- R7: `we_n_o` is high at all times, including throughout every CBR sequence.
- R8: `done_o` is a one-cycle pulse in the last recovery cycle of each sequence. On the next cycle RAS_n and CAS_n are high and `done_o` is low.
- R9: The row counter behaves as follows:
  - `row_o` is 0 after reset.
  - It increments by one after each row-strobe-only sequence, wrapping from 2^`ROW_BITS`-1 to 0.
  - It is unchanged by CBR and hidden sequences.
- R10: During reset, `req_o` and `done_o` are low, `ras_n_o` and `cas_n_o` are high, and `row_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| grant_i | input | 1 | Access controller grants the pending refresh |
| mode_i | input | 2 | Refresh style: 00 row-strobe-only, 01/11 CBR, 10 hidden |
| req_o | output | 1 | At least one refresh is pending |
| done_o | output | 1 | One-cycle pulse at the end of a refresh sequence |
| ras_n_o | output | 1 | Row strobe to the DRAM, active low |
| cas_n_o | output | 1 | Column strobe to the DRAM, active low |
| we_n_o | output | 1 | Write enable to the DRAM, held high |
| row_o | output | ROW_BITS | Row address for row-strobe-only refresh |

## Verification
The assertions take all three timing parameters to be at least one cycle, and they read `mode_i` only in the cycle a grant is accepted. The RAS low-width check counts cycles from reset, so it assumes no RAS pulse is in flight when reset is released.

The stimulus keeps within these assumptions:
- It raises `grant_i` for a single cycle while the block is idle, and changes `mode_i` only in that same cycle.
- It also pulses grants with no request pending, to show they are ignored.
- Before each pending-count scenario it aligns to a known phase of the interval timer, so that no expiry lands while the pending count is being drained.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    MODE_ROW_ONLY = 2'b00,
    MODE_CBR      = 2'b01,
    MODE_HIDDEN   = 2'b10,
    MODE_CBR_ALT  = 2'b11
  } ref_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_LEAD  = 2'b01,
    ST_ACT   = 2'b10,
    ST_RECOV = 2'b11
  } ref_state_e;

endpackage

// File: rtl/ref_rst_sync.sv
module ref_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int INTERVAL = 3900,
  parameter int PEND_W   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  output logic req_o
);

  localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0]  LAST     = CNT_W'(INTERVAL - 1);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              tick;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    pend_d = pend_q;
    unique case ({tick, done_i})
      2'b10:   if (pend_q != PEND_MAX) pend_d = pend_q + 1'b1;
      2'b01:   if (pend_q != '0)       pend_d = pend_q - 1'b1;
      default: pend_d = pend_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign req_o = (pend_q != '0);

  // R2
  req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_o) |-> $past(done_i));

  // R1
  tick_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !done_i) |=> req_o);

  // R2
  pend_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == PEND_MAX && !done_i) |=> pend_q == PEND_MAX);

endmodule

// File: rtl/ref_row_counter.sv
module ref_row_counter #(
  parameter int ROW_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_i,
  output logic [ROW_BITS-1:0] row_o
);

  logic [ROW_BITS-1:0] row_q, row_d;

  always_comb begin
    row_d = step_i ? row_q + 1'b1 : row_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  assign row_o = row_q;

  // R9
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> row_o == $past(row_o) + 1'b1);

  // R9
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(row_o));

endmodule

// File: rtl/ref_seq_fsm.sv
module ref_seq_fsm
  import dram_ref_pkg::*;
#(
  parameter int T_RAS = 18,
  parameter int T_RP  = 13,
  parameter int T_CSR = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_i,
  input  logic      grant_i,
  input  ref_mode_e mode_i,
  output logic      ras_n_o,
  output logic      cas_n_o,
  output logic      done_o,
  output logic      row_step_o
);

  localparam int TMAX1 = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int TMAX  = (TMAX1 > T_CSR) ? TMAX1 : T_CSR;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int LW    = $clog2(T_RAS + 2);

  ref_state_e     st_q, st_d;
  ref_mode_e      mode_q, mode_d;
  logic [TW-1:0]  tcnt_q, tcnt_d;
  logic           last_cyc;

  assign last_cyc = (tcnt_q == '0);

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    tcnt_d = tcnt_q;
    done_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_i && grant_i) begin
          st_d   = ST_LEAD;
          mode_d = mode_i;
          tcnt_d = (mode_i == MODE_HIDDEN) ? TW'(T_RP - 1) : TW'(T_CSR - 1);
        end
      end
      ST_LEAD: begin
        if (last_cyc) begin
          st_d   = ST_ACT;
          tcnt_d = TW'(T_RAS - 1);
        end else begin
          tcnt_d = tcnt_q - 1'b1;
        end
      end
      ST_ACT: begin
        if (last_cyc) begin
          st_d   = ST_RECOV;
          tcnt_d = TW'(T_RP - 1);
        end else begin
          tcnt_d = tcnt_q - 1'b1;
        end
      end
      ST_RECOV: begin
        if (last_cyc) begin
          st_d   = ST_IDLE;
          done_o = 1'b1;
        end else begin
          tcnt_d = tcnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_CBR;
      tcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign ras_n_o    = (st_q != ST_ACT);
  assign cas_n_o    = !(((st_q == ST_LEAD) || (st_q == ST_ACT)) && (mode_q != MODE_ROW_ONLY));
  assign row_step_o = done_o && (mode_q == MODE_ROW_ONLY);

  // checker state: length of the current RAS low pulse
  logic [LW-1:0] low_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_len_q <= '0;
    else if (!ras_n_o) low_len_q <= low_len_q + 1'b1;
    else               low_len_q <= '0;
  end

  // R4
  cas_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n_o) |-> ras_n_o);

  // R5
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_o) |-> low_len_q == LW'(T_RAS));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (ras_n_o && cas_n_o && !done_o));

  // R3
  no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !req_i) |=> st_q == ST_IDLE);

  initial begin
    // R4
    timing_param_chk: assert (T_RAS >= 1 && T_RP >= 1 && T_CSR >= 1);
  end

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int INTERVAL = 3900,
  parameter int PEND_W   = 3,
  parameter int ROW_BITS = 10,
  parameter int T_RAS    = 18,
  parameter int T_RP     = 13,
  parameter int T_CSR    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                grant_i,
  input  logic [1:0]          mode_i,
  output logic                req_o,
  output logic                done_o,
  output logic                ras_n_o,
  output logic                cas_n_o,
  output logic                we_n_o,
  output logic [ROW_BITS-1:0] row_o
);

  logic rst_n_int;
  logic row_step;

  ref_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ref_interval_timer #(
    .INTERVAL (INTERVAL),
    .PEND_W   (PEND_W)
  ) i_timer (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .done_i (done_o),
    .req_o  (req_o)
  );

  ref_seq_fsm #(
    .T_RAS (T_RAS),
    .T_RP  (T_RP),
    .T_CSR (T_CSR)
  ) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .req_i      (req_o),
    .grant_i    (grant_i),
    .mode_i     (ref_mode_e'(mode_i)),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o),
    .done_o     (done_o),
    .row_step_o (row_step)
  );

  ref_row_counter #(
    .ROW_BITS (ROW_BITS)
  ) i_row (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .step_i (row_step),
    .row_o  (row_o)
  );

  assign we_n_o = 1'b1;

  // R7
  we_high_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !cas_n_o |-> we_n_o);

endmodule

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;

  localparam int INTERVAL = 40;
  localparam int PEND_W   = 2;
  localparam int RB       = 10;
  localparam int T_RAS    = 3;
  localparam int T_RP     = 2;
  localparam int T_CSR    = 2;
  localparam int PMAX     = (1 << PEND_W) - 1;

  logic          clk;
  logic          rst_n;
  logic          grant;
  logic [1:0]    mode;
  logic          req, done, ras_n, cas_n, we_n;
  logic [RB-1:0] row;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit finished = 0;

  dram_refresh_sched #(
    .INTERVAL (INTERVAL), .PEND_W (PEND_W), .ROW_BITS (RB),
    .T_RAS (T_RAS), .T_RP (T_RP), .T_CSR (T_CSR)
  ) i_dram_refresh_sched (
    .clk (clk), .rst_n (rst_n), .grant_i (grant), .mode_i (mode),
    .req_o (req), .done_o (done), .ras_n_o (ras_n), .cas_n_o (cas_n),
    .we_n_o (we_n), .row_o (row)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // one refresh of the given mode; checks strobes, done, WE and row
  task automatic do_refresh(input logic [1:0] m, input string tag);
    int lead, tot, errs, weerr, rowerr;
    logic [RB-1:0] row0;
    lead = (m == 2'b10) ? T_RP : T_CSR;
    tot  = lead + T_RAS + T_RP;
    errs = 0; weerr = 0; rowerr = 0;
    while (!req) @(negedge clk);
    row0  = row;
    mode  = m;
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    for (int i = 0; i < tot; i++) begin
      logic e_ras, e_cas, e_done;
      e_ras  = !(i >= lead && i < lead + T_RAS);
      e_cas  = !(m != 2'b00 && i < lead + T_RAS);
      e_done = (i == tot - 1);
      if (ras_n !== e_ras || cas_n !== e_cas || done !== e_done) errs++;
      if (we_n !== 1'b1) weerr++;
      if (row !== row0) rowerr++;
      @(negedge clk);
    end
    check(errs == 0, tag, errs, 0);
    check(weerr == 0, "R7 we high", weerr, 0);
    check(done == 1'b0 && ras_n && cas_n, "R8 done single pulse", done, 0);
    if (m == 2'b00) begin
      check(rowerr == 0, "R5 row stable", rowerr, 0);
      check(row == RB'(row0 + 1'b1), "R9 row step", row, RB'(row0 + 1'b1));
    end else begin
      check(row == row0, "R9 row unchanged", row, row0);
    end
  endtask

  task automatic wait_phase(input int ph);
    @(negedge clk);
    while (((cyc - 2) % INTERVAL) != ph) @(negedge clk);
  endtask

  task automatic drain(output int n);
    n = 0;
    @(negedge clk);
    while (req) begin
      do_refresh(2'b01, "R4 cbr drain");
      n++;
    end
  endtask

  task automatic t_reset();
    check(req == 1'b0 && done == 1'b0, "R10 req/done low", {req, done}, 0);
    check(ras_n == 1'b1 && cas_n == 1'b1, "R10 strobes high", {ras_n, cas_n}, 3);
    check(row == '0, "R10 row zero", row, 0);
  endtask

  task automatic t_grant_ignored();
    int errs = 0;
    while (cyc < 10) @(negedge clk);
    mode  = 2'b01;
    grant = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!ras_n || !cas_n || done || req) errs++;
    end
    grant = 1'b0;
    check(errs == 0, "R3 grant without request", errs, 0);
  endtask

  task automatic t_first_req();
    while (cyc < INTERVAL + 1) @(negedge clk);
    check(req == 1'b0, "R1 req before interval", req, 0);
    @(negedge clk);
    check(req == 1'b1, "R1 req at interval", req, 1);
  endtask

  task automatic t_modes();
    do_refresh(2'b01, "R4 cbr sequence");
    do_refresh(2'b00, "R5 row-only sequence");
    do_refresh(2'b10, "R6 hidden sequence");
    do_refresh(2'b11, "R4 cbr alias sequence");
  endtask

  task automatic t_pending_accum();
    int n;
    wait_phase(5);
    drain(n);
    wait_phase(5);
    repeat (INTERVAL) @(negedge clk);
    // two expiries since the drain
    do_refresh(2'b01, "R4 cbr pending");
    check(req == 1'b1, "R2 second still pending", req, 1);
    do_refresh(2'b01, "R4 cbr pending");
    check(req == 1'b0, "R2 pending empty", req, 0);
  endtask

  task automatic t_pending_sat();
    int n;
    wait_phase(5);
    drain(n);
    wait_phase(5);
    repeat (4 * INTERVAL) @(negedge clk);
    drain(n);
    check(n == PMAX, "R2 pending saturates", n, PMAX);
  endtask

  task automatic t_grant_busy();
    int errs = 0;
    while (!req) @(negedge clk);
    mode  = 2'b00;
    grant = 1'b1;
    @(negedge clk);
    // grant held through the sequence must not restart it
    for (int i = 0; i < T_CSR + T_RAS + T_RP; i++) @(negedge clk);
    grant = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (!ras_n || !cas_n) errs++;
      @(negedge clk);
    end
    check(errs == 0 || req, "R3 grant while busy", errs, 0);
  endtask

  task automatic t_row_wrap();
    int guard = 0;
    while (row != RB'((1 << RB) - 1) && guard < 1100) begin
      int lead, tot;
      lead = T_CSR;
      tot  = lead + T_RAS + T_RP;
      while (!req) @(negedge clk);
      mode  = 2'b00;
      grant = 1'b1;
      @(negedge clk);
      grant = 1'b0;
      repeat (tot) @(negedge clk);
      guard++;
    end
    check(row == RB'((1 << RB) - 1), "R9 row reaches top", row, (1 << RB) - 1);
    do_refresh(2'b00, "R5 row-only at top");
    check(row == '0, "R9 row wraps to zero", row, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    grant = 1'b0;
    mode  = 2'b00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_grant_ignored();
    t_first_req();
    t_modes();
    t_pending_accum();
    t_pending_sat();
    t_grant_busy();
    t_row_wrap();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule